// File: doc/BRIEF.md
# Interleaved Two-Phase PWM Generator with Current Sharing and Cycle-Skip Limit

This block drives the switches of a two-phase synchronous buck stage from a single duty command. One free-running counter sets the switching period. The second phase runs on the same counter, shifted by half a period, so the two phases interleave. Each phase has a complementary pair of enables: a high-side enable and a low-side enable. The low side is on whenever the high side is off. Each phase also raises a one-clock sample strobe. On that strobe the block captures a signed, already quantized phase-current value from its input.

At every period start, each phase latches a new on-time. The on-time is the duty command plus a sharing trim that moves the phase toward the mean of the two captured currents. The result is clipped to three quarters of the period. If a phase's captured current is above the overcurrent limit, that phase skips its whole next period: its low side stays on and its high side stays off. The phase starts switching again at the first period start after a captured current is back at or below the limit. The strobe fires only when the off interval is long enough for a valid current reading. When it does not fire, the phase keeps its previous captured value.

Top module: `dpwm_ctrl`

## Requirements
- R1: While `rst` is high, both high-side enables are 0, both low-side enables are 1 and both strobes are 0.
- R2: The switching period is `PERIOD` clocks. Phase A's high side turns on at counter value 0 and stays on for its latched on-time. Phase B does the same starting `PERIOD/2` clocks later.
- R3: In every cycle, each phase's low-side enable is the inverse of its high-side enable.
- R4: The on-time latched at a period start is `duty_cmd + floor((m - s_k) / 2^SHARE_SHIFT)`. Here `s_k` is the phase's own captured signed current and `m = floor((s_a + s_b) / 2)`. Negative currents count in the mean.
- R5: The latched on-time saturates to the range from 0 to `3*PERIOD/4` clocks. With the defaults this range is 0 to 24.
- R6: A strobe pulses for one clock in the last clock of the phase's period, which lies in the second half of its off interval. The current on that phase's input in that clock becomes the captured value, and the on-time latched at the following period start already uses it.
- R7: A strobe fires only if floor(off-time / 2) is at least `TRACK_MIN` clocks (default 5). Otherwise there is no strobe and the previous captured value is kept.
- R8: If a phase's captured current is greater than `OC_LIMIT` (default 35), that phase's next whole period has its high side off and its low side on. A value equal to the limit is not an overcurrent.
- R9: After an overcurrent, the high side switches again at the first period start that follows a capture at or below the limit, with the on-time given by R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_cmd | input | CW = clog2(PERIOD+1) | Requested on-time in clocks per period |
| cur_a | input | IW | Signed current value for phase A |
| cur_b | input | IW | Signed current value for phase B |
| hs_en | output | 2 | High-side enable, bit 0 for phase A, bit 1 for phase B |
| ls_en | output | 2 | Low-side enable, bit 0 for phase A, bit 1 for phase B |
| smp_stb | output | 2 | Current capture strobe, bit 0 for phase A, bit 1 for phase B |

## Verification
The bench targets the signed mean with one negative phase current. A design that truncated toward zero, or treated the values as unsigned, would be off by a clock or grossly wrong there. It drives currents of exactly 35 and 36. A comparison that is off by one would skip on the wrong one. It requests a duty above the ceiling and a trim below zero, which catches a wrapping or missing clamp. At the ceiling the off time is too short for a reading, and the bench changes the currents to values that would force a skip. A design that still captured them would switch off phase A and alter both on-times. A single recovery period is checked cycle by cycle, which catches a design that lingers in the skip state for an extra period.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   localparam int NPH = 2;

   // Start offset of leg k inside the shared period, in clocks.
   function automatic int leg_offset(input int period, input int k);
      return (k * period) / NPH;
   endfunction

endpackage

// File: rtl/dpwm_tbase.sv
module dpwm_tbase #(
   parameter int PERIOD = 32,
   parameter int CW     = 6
) (
   input  logic          clk,
   input  logic          rst,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (cnt == LAST)
         cnt <= '0;
      else
         cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/dpwm_share.sv
module dpwm_share #(
   parameter int IW          = 8,
   parameter int CW          = 6,
   parameter int SHARE_SHIFT = 1,
   parameter int DMAX        = 24
) (
   input  logic [CW-1:0]        duty_cmd,
   input  logic signed [IW-1:0] eff      [dpwm_pkg::NPH],
   output logic [CW-1:0]        duty_adj [dpwm_pkg::NPH]
);

   localparam int AW = IW + 2;
   localparam int RW = ((CW > AW) ? CW : AW) + 2;

   logic signed [AW-1:0] sum_w;
   logic signed [AW-1:0] mean_w;

   assign sum_w  = AW'(eff[0]) + AW'(eff[1]);
   assign mean_w = sum_w >>> 1;

   for (genvar k = 0; k < dpwm_pkg::NPH; k++) begin : g_leg
      logic signed [AW-1:0] diff_w;
      logic signed [AW-1:0] trim_w;
      logic signed [RW-1:0] raw_w;

      assign diff_w = mean_w - AW'(eff[k]);

      if (SHARE_SHIFT == 0) begin : g_unity
         assign trim_w = diff_w;
      end else begin : g_shift
         assign trim_w = diff_w >>> SHARE_SHIFT;
      end

      assign raw_w = RW'($signed({1'b0, duty_cmd})) + RW'(trim_w);

      always_comb begin
         if (raw_w < RW'(0))
            duty_adj[k] = '0;
         else if (raw_w > RW'(DMAX))
            duty_adj[k] = CW'(DMAX);
         else
            duty_adj[k] = raw_w[CW-1:0];
      end
   end

endmodule

// File: rtl/dpwm_leg.sv
module dpwm_leg #(
   parameter int PERIOD    = 32,
   parameter int OFFSET    = 0,
   parameter int CW        = 6,
   parameter int IW        = 8,
   parameter int TRACK_MIN = 5,
   parameter int OC_LIMIT  = 35
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [CW-1:0]        cnt,
   input  logic signed [IW-1:0] cur,
   input  logic [CW-1:0]        duty_adj,
   output logic signed [IW-1:0] eff,
   output logic                 hs,
   output logic                 ls,
   output logic                 stb
);

   logic [CW:0]          wrap_sum;
   logic [CW-1:0]        local_cnt;
   logic [CW-1:0]        on_lat;
   logic [CW-1:0]        off_len;
   logic                 skip_q;
   logic signed [IW-1:0] samp_q;
   logic                 at_end;
   logic                 track_ok;

   assign wrap_sum  = {1'b0, cnt} + (CW+1)'(OFFSET);
   assign local_cnt = (wrap_sum >= (CW+1)'(PERIOD)) ? CW'(wrap_sum - (CW+1)'(PERIOD))
                                                    : CW'(wrap_sum);
   assign at_end    = (local_cnt == CW'(PERIOD - 1));

   // Off interval of the running period, and whether its second half can hold a reading.
   assign off_len   = skip_q ? CW'(PERIOD) : (CW'(PERIOD) - on_lat);
   assign track_ok  = ((off_len >> 1) >= CW'(TRACK_MIN));
   assign stb       = at_end && track_ok;
   assign eff       = stb ? cur : samp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         on_lat <= '0;
         skip_q <= 1'b0;
         samp_q <= '0;
      end else begin
         if (stb)
            samp_q <= cur;
         if (at_end) begin
            on_lat <= duty_adj;
            skip_q <= (eff > IW'(OC_LIMIT));
         end
      end
   end

   assign hs = !skip_q && (local_cnt < on_lat);
   assign ls = !hs;

endmodule

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl #(
   parameter int  PERIOD      = 32,
   parameter int  IW          = 8,
   parameter int  SHARE_SHIFT = 1,
   parameter int  OC_LIMIT    = 35,
   parameter int  TRACK_MIN   = 5,
   localparam int CW          = $clog2(PERIOD + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [CW-1:0]        duty_cmd,
   input  logic signed [IW-1:0] cur_a,
   input  logic signed [IW-1:0] cur_b,
   output logic [1:0]           hs_en,
   output logic [1:0]           ls_en,
   output logic [1:0]           smp_stb
);

   localparam int DMAX = (3 * PERIOD) / 4;

   if ((PERIOD % 4) != 0 || PERIOD < 8) begin : g_bad_period
      $error("PERIOD must be a multiple of 4 and at least 8");
   end
   if (2 * TRACK_MIN > PERIOD) begin : g_bad_track
      $error("TRACK_MIN too large for PERIOD");
   end
   if (OC_LIMIT >= (1 << (IW - 1)) || OC_LIMIT < 0) begin : g_bad_limit
      $error("OC_LIMIT does not fit the current width");
   end

   logic [CW-1:0]        cnt;
   logic signed [IW-1:0] cur_arr  [dpwm_pkg::NPH];
   logic signed [IW-1:0] eff      [dpwm_pkg::NPH];
   logic [CW-1:0]        duty_adj [dpwm_pkg::NPH];

   assign cur_arr[0] = cur_a;
   assign cur_arr[1] = cur_b;

   dpwm_tbase #(.PERIOD(PERIOD), .CW(CW)) u_tbase (
      .clk (clk),
      .rst (rst),
      .cnt (cnt)
   );

   dpwm_share #(.IW(IW), .CW(CW), .SHARE_SHIFT(SHARE_SHIFT), .DMAX(DMAX)) u_share (
      .duty_cmd (duty_cmd),
      .eff      (eff),
      .duty_adj (duty_adj)
   );

   for (genvar k = 0; k < dpwm_pkg::NPH; k++) begin : g_legs
      dpwm_leg #(
         .PERIOD    (PERIOD),
         .OFFSET    (dpwm_pkg::leg_offset(PERIOD, k)),
         .CW        (CW),
         .IW        (IW),
         .TRACK_MIN (TRACK_MIN),
         .OC_LIMIT  (OC_LIMIT)
      ) u_leg (
         .clk      (clk),
         .rst      (rst),
         .cnt      (cnt),
         .cur      (cur_arr[k]),
         .duty_adj (duty_adj[k]),
         .eff      (eff[k]),
         .hs       (hs_en[k]),
         .ls       (ls_en[k]),
         .stb      (smp_stb[k])
      );
   end

endmodule

// File: rtl/dpwm_ctrl_chk.sv
module dpwm_ctrl_chk #(
   parameter int PERIOD    = 32,
   parameter int TRACK_MIN = 5
) (
   input logic       clk,
   input logic       rst,
   input logic [1:0] hs_en,
   input logic [1:0] ls_en,
   input logic [1:0] smp_stb
);

   localparam int DMAX = (3 * PERIOD) / 4;

   logic [15:0] ccnt;

   always_ff @(posedge clk) begin
      if (rst)
         ccnt <= '0;
      else if (ccnt == 16'(PERIOD - 1))
         ccnt <= '0;
      else
         ccnt <= ccnt + 16'd1;
   end

   for (genvar k = 0; k < 2; k++) begin : g_ph
      logic [15:0] hi_run;
      logic [15:0] lo_run;

      always_ff @(posedge clk) begin
         if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
         end else begin
            hi_run <= hs_en[k] ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1) : '0;
            lo_run <= ls_en[k] ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1) : '0;
         end
      end

      // R2: high side only rises at this phase's own period start
      assert_rise_slot_R2: assert property (@(posedge clk) disable iff (rst)
         $rose(hs_en[k]) |-> (ccnt == 16'(k * PERIOD / 2)));

      // R5: no high-side run longer than the duty ceiling
      assert_on_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
         hs_en[k] |-> (hi_run < 16'(DMAX)));

      // R6: strobe only while the high side is off
      assert_stb_in_off_R6: assert property (@(posedge clk) disable iff (rst)
         smp_stb[k] |-> (!hs_en[k] && ls_en[k]));

      // R7: strobe only after an off interval long enough for a reading
      assert_stb_track_R7: assert property (@(posedge clk) disable iff (rst)
         smp_stb[k] |-> (lo_run >= 16'(2 * TRACK_MIN - 1)));
   end

endmodule

bind dpwm_ctrl dpwm_ctrl_chk #(.PERIOD(PERIOD), .TRACK_MIN(TRACK_MIN)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .hs_en   (hs_en),
   .ls_en   (ls_en),
   .smp_stb (smp_stb)
);

// File: tb/tb_dpwm_ctrl.sv
`timescale 1ns/1ps
module tb_dpwm_ctrl;

   localparam int P    = 32;
   localparam int IW   = 8;
   localparam int SH   = 1;
   localparam int OCL  = 35;
   localparam int TM   = 5;
   localparam int CW   = $clog2(P + 1);
   localparam int DMAX = (3 * P) / 4;

   typedef struct {
      int    idx;
      int    on;
      int    stb;
      string tag;
   } exp_t;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic [CW-1:0]        duty_cmd = '0;
   logic signed [IW-1:0] cur_a = '0;
   logic signed [IW-1:0] cur_b = '0;
   logic [1:0]           hs_en, ls_en, smp_stb;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   comp_err = 0;
   bit   done = 1'b0;
   exp_t q [2][$];

   int   acc_on [2];
   int   first_hi [2];
   int   acc_stb [2];
   int   stb_loc [2];

   always #4 clk = ~clk;

   dpwm_ctrl #(.PERIOD(P), .IW(IW), .SHARE_SHIFT(SH), .OC_LIMIT(OCL), .TRACK_MIN(TM)) dut (
      .clk      (clk),
      .rst      (rst),
      .duty_cmd (duty_cmd),
      .cur_a    (cur_a),
      .cur_b    (cur_b),
      .hs_en    (hs_en),
      .ls_en    (ls_en),
      .smp_stb  (smp_stb)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Expected on-time from R4, R5 and R8
   function automatic int exp_on(input int d, input int s_own, input int s_oth);
      int m;
      int v;
      m = (s_own + s_oth) >>> 1;
      v = d + ((m - s_own) >>> SH);
      if (v < 0) v = 0;
      if (v > DMAX) v = DMAX;
      if (s_own > OCL) v = 0;
      return v;
   endfunction

   // Expected strobe count per period from R6 and R7
   function automatic int exp_stb(input int on);
      return (((P - on) / 2) >= TM) ? 1 : 0;
   endfunction

   // Monitor: per-phase period accounting, compared against the queue
   always @(negedge clk) begin
      if (rst) begin
         cyc = 0;
         for (int k = 0; k < 2; k++) begin
            acc_on[k] = 0; first_hi[k] = -1; acc_stb[k] = 0; stb_loc[k] = -1;
         end
      end else begin
         for (int k = 0; k < 2; k++) begin
            int off;
            int loc;
            int idx;
            off = k * (P / 2);
            loc = (cyc + off) % P;
            if (loc == 0) begin
               acc_on[k] = 0; first_hi[k] = -1; acc_stb[k] = 0; stb_loc[k] = -1;
            end
            if (hs_en[k] == ls_en[k]) comp_err++;
            if (hs_en[k]) begin
               if (first_hi[k] < 0) first_hi[k] = loc;
               acc_on[k]++;
            end
            if (smp_stb[k]) begin
               acc_stb[k]++;
               stb_loc[k] = loc;
            end
            if (loc == P - 1) begin
               idx = (cyc + off) / P - k;
               if (q[k].size() > 0 && q[k][0].idx == idx) begin
                  exp_t e;
                  e = q[k].pop_front();
                  chk($sformatf("%s ph%0d on-time", e.tag, k), acc_on[k], e.on);
                  if (e.on > 0)
                     chk($sformatf("R2 ph%0d high side starts at period start", k), first_hi[k], 0);
                  chk($sformatf("%s ph%0d strobe count", e.tag, k), acc_stb[k], e.stb);
                  if (e.stb > 0)
                     chk($sformatf("R6 ph%0d strobe in last clock", k), stb_loc[k], P - 1);
               end
            end
         end
         cyc++;
      end
   end

   task automatic sync_period(output int p);
      do begin
         @(posedge clk);
         #1;
      end while ((cyc % P) != 0);
      p = cyc / P;
   endtask

   task automatic drain();
      while (q[0].size() > 0 || q[1].size() > 0) @(negedge clk);
   endtask

   // Driver: apply inputs at a period start, then expect steady results
   task automatic run_case(input string tag, input int d, input int ca, input int cb,
                           input int sa, input int sb);
      int p;
      int on_a;
      int on_b;
      sync_period(p);
      duty_cmd = CW'(d);
      cur_a    = IW'(ca);
      cur_b    = IW'(cb);
      on_a = exp_on(d, sa, sb);
      on_b = exp_on(d, sb, sa);
      for (int n = 3; n < 5; n++) begin
         q[0].push_back('{idx: p + n, on: on_a, stb: exp_stb(on_a), tag: tag});
         q[1].push_back('{idx: p + n, on: on_b, stb: exp_stb(on_b), tag: tag});
      end
      drain();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual %0d expected %0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int p;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 hs_en in reset", int'(hs_en), 0);
      chk("R1 ls_en in reset", int'(ls_en), 3);
      chk("R1 smp_stb in reset", int'(smp_stb), 0);
      @(posedge clk);
      #1;
      rst = 1'b0;

      run_case("R4 equal currents", 16, 20, 20, 20, 20);
      run_case("R4 unequal currents", 16, 30, 10, 30, 10);
      run_case("R4 negative current", 12, 10, -20, 10, -20);
      run_case("R8 overcurrent skip", 16, 40, 20, 40, 20);
      run_case("R8 at threshold", 16, 35, 20, 35, 20);
      run_case("R8 one above threshold", 16, 36, 20, 36, 20);

      // R9: release the overcurrent inside a skipped period
      sync_period(p);
      cur_a = IW'(20);
      q[0].push_back('{idx: p, on: 0, stb: 1, tag: "R9 skipped period"});
      q[0].push_back('{idx: p + 1, on: exp_on(16, 20, 20), stb: 1, tag: "R9 resume next period"});
      drain();

      run_case("R4 zero currents", 16, 0, 0, 0, 0);
      run_case("R5 ceiling clamp", 30, 0, 0, 0, 0);
      // R7: short off interval keeps the earlier zero captures
      run_case("R7 capture retained", 30, 50, -20, 0, 0);
      run_case("R5 floor clamp", 2, 30, -30, 30, -30);

      chk("R3 ls_en complement of hs_en", comp_err, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule